// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host's byte-wide write port and the operation engine of a parallel flash model. It watches each host write (address, data and a level write strobe) and recognises the address-qualified unlock grammar that guards every flash operation. Every command begins with two key writes: AA to 5555, then 55 to 2AAA. A third write then picks the command. A0 arms a byte program, and the next write supplies the target address and data. 80 opens an erase setup that repeats the two key writes and then branches on a sixth data byte. 90 enters the identification mode and F0 leaves it.

A recognised sequence produces a one-cycle command pulse, the captured target address and data where the command needs them, and a level flag that shows whether identification mode is active. A busy input from the operation engine makes the decoder drop writes while an operation runs, and it clears any partly entered sequence. A single F0 write to any address leaves identification mode without the key writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rstN` is low, every command pulse is 0, `idMode` is 0 and the decoder waits for the first key write.
- R2: The writes AA@5555, 55@2AAA, A0@5555 followed by any write pulse `cmdProgram`, load that write's address into `tgtAddr` and its data into `tgtData`.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 pulse `cmdChipErase`.
- R4: The same five-write erase setup followed by data 30 at any address pulses `cmdSectorErase` and loads that address into `tgtAddr`.
- R5: The erase setup followed by 40@5555 pulses `cmdBootLock`.
- R6: The writes AA@5555, 55@2AAA, 90@5555 pulse `cmdIdEnter` and set `idMode` to 1. The writes AA@5555, 55@2AAA, F0@5555 pulse `cmdIdExit` and clear `idMode`.
- R7: From the idle state, a single write of F0 to any address pulses `cmdIdExit` and clears `idMode`.
- R8: A write's address is taken in the first clock where `wrEn` is 1. Its data is taken in the first clock where `wrEn` is back at 0. Address changes while `wrEn` is high have no effect, and so do data changes before the release.
- R9: A write whose address or data does not match the expected step returns the decoder to idle and issues no command. Only data F0 in idle is an exception (R7).
- R10: While `busy` is 1, writes issue no command and the partly entered sequence is cleared.
- R11: Only `addr[14:0]` is compared against 5555 and 2AAA. Bits 16:15 are ignored for the key writes.
- R12: A command pulse is 1 for exactly one clock: the clock after the one in which the releasing `wrEn`=0 is sampled. At most one command pulse is 1 at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, high for the duration of a write |
| addr | input | 17 | Host write address |
| data | input | 8 | Host write data |
| busy | input | 1 | Operation engine busy; writes are dropped while high |
| cmdProgram | output | 1 | One-cycle byte program command |
| cmdChipErase | output | 1 | One-cycle chip erase command |
| cmdSectorErase | output | 1 | One-cycle sector erase command |
| cmdBootLock | output | 1 | One-cycle boot block lockout command |
| cmdIdEnter | output | 1 | One-cycle identification entry command |
| cmdIdExit | output | 1 | One-cycle identification exit command |
| tgtAddr | output | 17 | Address captured for program and sector erase |
| tgtData | output | 8 | Data captured for program |
| idMode | output | 1 | Identification mode is active |

## Verification
The hardest case to reach is a sequence cut short part-way. One way is a busy pulse that lands between the second key write and the command byte. The other is a key write whose address differs from the key only in a compared bit. Either can only be seen when a later, otherwise valid-looking write produces no command. The stimulus enters two key writes, raises busy for one clock and then sends the program byte and a target write, and the scoreboard expects nothing. Every write also holds a wrong address during release and wrong data during assertion, so a decoder that samples either at the wrong moment is caught on each command.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int BYTE_W = 8;
  localparam int KEY_W  = 15;

  localparam logic [KEY_W-1:0]  KEY_ADDR_1 = 15'h5555;
  localparam logic [KEY_W-1:0]  KEY_ADDR_2 = 15'h2AAA;
  localparam logic [BYTE_W-1:0] KEY_DATA_1 = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_DATA_2 = 8'h55;
  localparam logic [BYTE_W-1:0] OP_PROGRAM = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_ID_IN   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ID_OUT  = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_CHIP    = 8'h10;
  localparam logic [BYTE_W-1:0] OP_SECTOR  = 8'h30;
  localparam logic [BYTE_W-1:0] OP_BOOT    = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3
  } seqState_t;

  typedef struct packed {
    logic loadTgt;
    logic doProg;
    logic doChip;
    logic doSector;
    logic doBoot;
    logic idEnter;
    logic idExit;
  } cmdStrobe_t;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int CMP_W = KEY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              fallEv,
  input  logic [CMP_W-1:0]  cmpAddr,
  input  logic [BYTE_W-1:0] wrData,
  output cmdStrobe_t        strobe
);
  localparam logic [CMP_W-1:0] keyA = CMP_W'(KEY_ADDR_1);
  localparam logic [CMP_W-1:0] keyB = CMP_W'(KEY_ADDR_2);

  seqState_t state, nxt;
  logic atKeyA, atKeyB;

  assign atKeyA = (cmpAddr == keyA);
  assign atKeyB = (cmpAddr == keyB);

  always_comb begin
    nxt    = state;
    strobe = '0;
    if (busy) begin
      nxt = ST_IDLE;
    end else if (fallEv) begin
      nxt = ST_IDLE;
      unique case (state)
        ST_IDLE: begin
          if (atKeyA && wrData == KEY_DATA_1) nxt = ST_KEY1;
          else if (wrData == OP_ID_OUT)       strobe.idExit = 1'b1;
        end
        ST_KEY1: if (atKeyB && wrData == KEY_DATA_2) nxt = ST_KEY2;
        ST_KEY2: begin
          if (atKeyA) begin
            case (wrData)
              OP_PROGRAM: nxt = ST_PROG;
              OP_ERASE:   nxt = ST_ERS1;
              OP_ID_IN:   strobe.idEnter = 1'b1;
              OP_ID_OUT:  strobe.idExit = 1'b1;
              default:    nxt = ST_IDLE;
            endcase
          end
        end
        ST_PROG: begin
          strobe.doProg  = 1'b1;
          strobe.loadTgt = 1'b1;
        end
        ST_ERS1: if (atKeyA && wrData == KEY_DATA_1) nxt = ST_ERS2;
        ST_ERS2: if (atKeyB && wrData == KEY_DATA_2) nxt = ST_ERS3;
        ST_ERS3: begin
          if (wrData == OP_SECTOR) begin
            strobe.doSector = 1'b1;
            strobe.loadTgt  = 1'b1;
          end else if (atKeyA && wrData == OP_CHIP) begin
            strobe.doChip = 1'b1;
          end else if (atKeyA && wrData == OP_BOOT) begin
            strobe.doBoot = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> state == ST_IDLE); // R10
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> strobe == '0); // R10
  AST_ADVANCE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) |-> $past(fallEv || busy)); // R8
endmodule

// File: rtl/fcd_dpath.sv
module fcd_dpath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = KEY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  input  cmdStrobe_t        strobe,
  output logic              fallEv,
  output logic [CMP_W-1:0]  cmpAddr,
  output logic              cmdProgram,
  output logic              cmdChipErase,
  output logic              cmdSectorErase,
  output logic              cmdBootLock,
  output logic              cmdIdEnter,
  output logic              cmdIdExit,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [BYTE_W-1:0] tgtData,
  output logic              idMode
);
  logic              wrPrev;
  logic [ADDR_W-1:0] addrLat;
  logic [5:0]        pulseVec;

  assign fallEv  = wrPrev & ~wrEn;
  assign cmpAddr = addrLat[CMP_W-1:0];
  assign {cmdProgram, cmdChipErase, cmdSectorErase,
          cmdBootLock, cmdIdEnter, cmdIdExit} = pulseVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      addrLat  <= '0;
      pulseVec <= '0;
      tgtAddr  <= '0;
      tgtData  <= '0;
      idMode   <= 1'b0;
    end else begin
      wrPrev   <= wrEn;
      if (wrEn && !wrPrev) addrLat <= addr;
      pulseVec <= {strobe.doProg, strobe.doChip, strobe.doSector,
                   strobe.doBoot, strobe.idEnter, strobe.idExit};
      if (strobe.loadTgt) begin
        tgtAddr <= addrLat;
        tgtData <= data;
      end
      if (strobe.idEnter)     idMode <= 1'b1;
      else if (strobe.idExit) idMode <= 1'b0;
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulseVec)); // R12
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseVec) |=> !(|pulseVec)); // R12
  AST_ID_SET: assert property (@(posedge clk) disable iff (!rstN)
    cmdIdEnter |-> idMode); // R6
  AST_ID_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cmdIdExit |-> !idMode); // R7
  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdProgram || cmdSectorErase) && $past(rstN) |-> $stable(tgtAddr)); // R4
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = KEY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  input  logic              busy,
  output logic              cmdProgram,
  output logic              cmdChipErase,
  output logic              cmdSectorErase,
  output logic              cmdBootLock,
  output logic              cmdIdEnter,
  output logic              cmdIdExit,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [BYTE_W-1:0] tgtData,
  output logic              idMode
);
  cmdStrobe_t       strobe;
  logic             fallEv;
  logic [CMP_W-1:0] cmpAddr;

  fcd_ctrl #(.CMP_W(CMP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busy(busy), .fallEv(fallEv),
    .cmpAddr(cmpAddr), .wrData(data), .strobe(strobe)
  );

  fcd_dpath #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .data(data),
    .strobe(strobe), .fallEv(fallEv), .cmpAddr(cmpAddr),
    .cmdProgram(cmdProgram), .cmdChipErase(cmdChipErase),
    .cmdSectorErase(cmdSectorErase), .cmdBootLock(cmdBootLock),
    .cmdIdEnter(cmdIdEnter), .cmdIdExit(cmdIdExit),
    .tgtAddr(tgtAddr), .tgtData(tgtData), .idMode(idMode)
  );
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int K_PROG = 0, K_CHIP = 1, K_SECT = 2, K_BOOT = 3, K_IDIN = 4, K_IDOUT = 5, K_NONE = -1;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, busy = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  data = '0;
  logic cmdProgram, cmdChipErase, cmdSectorErase, cmdBootLock, cmdIdEnter, cmdIdExit, idMode;
  logic [16:0] tgtAddr;
  logic [7:0]  tgtData;

  typedef struct {
    string       req;
    int          kind;
    logic [16:0] a;
    logic [7:0]  d;
    int          due;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0, cyc = 0, unexpected = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .data(data), .busy(busy),
    .cmdProgram(cmdProgram), .cmdChipErase(cmdChipErase), .cmdSectorErase(cmdSectorErase),
    .cmdBootLock(cmdBootLock), .cmdIdEnter(cmdIdEnter), .cmdIdExit(cmdIdExit),
    .tgtAddr(tgtAddr), .tgtData(tgtData), .idMode(idMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor: pops the expected command at the negedge where a pulse is seen (R12 timing).
  always @(negedge clk) begin
    if (rstN) begin
      int k;
      k = cmdProgram ? K_PROG : cmdChipErase ? K_CHIP : cmdSectorErase ? K_SECT :
          cmdBootLock ? K_BOOT : cmdIdEnter ? K_IDIN : cmdIdExit ? K_IDOUT : K_NONE;
      if (k != K_NONE) begin
        if (q.size() == 0) begin
          tests++; fails++; unexpected++;
          $display("FAIL R9: unexpected command actual %0d expected none", k);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.req, " kind"}, k, e.kind);
          chk("R12 pulse cycle", cyc, e.due);
          if (e.kind == K_PROG || e.kind == K_SECT) chk({e.req, " R8 tgtAddr"}, tgtAddr, e.a);
          if (e.kind == K_PROG) chk({e.req, " R8 tgtData"}, tgtData, e.d);
        end
      end
    end
  end

  // Driver: wrong data while asserted, wrong address while released (R8).
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input string req, input int kind);
    @(negedge clk); addr = a; data = ~d; wrEn = 1'b1;
    @(negedge clk); addr = a ^ 17'h1FFFF;
    @(negedge clk); wrEn = 1'b0; data = d; addr = ~a;
    if (kind != K_NONE) q.push_back('{req, kind, a, d, cyc + 1});
    @(negedge clk);
  endtask

  task automatic keys();
    wr(17'h05555, 8'hAA, "", K_NONE);
    wr(17'h02AAA, 8'h55, "", K_NONE);
  endtask

  task automatic eraseSetup();
    keys();
    wr(17'h05555, 8'h80, "", K_NONE);
    keys();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idMode", idMode, 0);
    chk("R1 pulses", {cmdProgram, cmdChipErase, cmdSectorErase, cmdBootLock, cmdIdEnter, cmdIdExit}, 0);
    rstN = 1'b1;
    @(negedge clk);

    keys(); wr(17'h05555, 8'hA0, "", K_NONE); wr(17'h01234, 8'h5A, "R2", K_PROG);
    eraseSetup(); wr(17'h05555, 8'h10, "R3", K_CHIP);
    eraseSetup(); wr(17'h16ABC, 8'h30, "R4", K_SECT);
    eraseSetup(); wr(17'h05555, 8'h40, "R5", K_BOOT);

    keys(); wr(17'h05555, 8'h90, "R6", K_IDIN);
    chk("R6 idMode set", idMode, 1);
    keys(); wr(17'h05555, 8'hF0, "R6", K_IDOUT);
    chk("R6 idMode clear", idMode, 0);

    keys(); wr(17'h05555, 8'h90, "R6", K_IDIN);
    wr(17'h10F0F, 8'hF0, "R7", K_IDOUT);
    chk("R7 idMode clear", idMode, 0);

    // R9 mismatches
    keys(); wr(17'h05555, 8'h77, "", K_NONE); wr(17'h01234, 8'h5A, "", K_NONE);
    wr(17'h05555, 8'hAA, "", K_NONE); wr(17'h02AAB, 8'h55, "", K_NONE);
    wr(17'h05555, 8'hA0, "", K_NONE); wr(17'h00000, 8'h00, "", K_NONE);
    eraseSetup(); wr(17'h05554, 8'h10, "", K_NONE);
    chk("R9 no stray command", unexpected, 0);

    // R10 busy drops writes and clears state
    busy = 1'b1;
    keys(); wr(17'h05555, 8'hA0, "", K_NONE); wr(17'h00200, 8'h11, "", K_NONE);
    busy = 1'b0;
    keys();
    @(negedge clk); busy = 1'b1; @(negedge clk); busy = 1'b0;
    wr(17'h05555, 8'hA0, "", K_NONE); wr(17'h00100, 8'h33, "", K_NONE);
    chk("R10 no command under busy", unexpected, 0);

    // R11 upper address bits ignored for keys
    wr(17'h15555, 8'hAA, "", K_NONE); wr(17'h0AAAA, 8'h55, "", K_NONE);
    wr(17'h1D555, 8'hA0, "", K_NONE); wr(17'h1FFFF, 8'hC3, "R11", K_PROG);

    repeat (4) @(negedge clk);
    chk("R9 scoreboard drained", q.size(), 0);
    chk("R10 final stray count", unexpected, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule